// File: doc/BRIEF.md
# Power Management Event Status Register with Button Conditioning

This block holds a 16-bit power management status word. Each defined bit is raised by a hardware event and stays raised until software writes a 1 to it; a 0 in the written word leaves the bit alone. The button bits carry most of the work. The raw active-low power and sleep button inputs are synchronized, then debounced on both edges against a slow timebase tick. A press is reported only after the new level has held for the debounce window. A press that lasts past a long hold threshold becomes an override event.

The other defined bits record single-cycle events. These are a toggle of the selected timer MSB, any bus-master request, a firmware release pulse, a real-time clock interrupt, and a resume event while the system is asleep. The debounce window and the hold threshold are parameters counted in ticks. The defaults assume a 32.768 kHz tick: about 14 ms for the debounce window and just over four seconds for the hold.

Top module: `pmEventStatus`

## Requirements
- R1: After reset the status word reads 0000h. The unused positions 14:12, 7:6 and 3:1 read 0 at all times, including after a write of FFFFh.
- R2: A write with `wrEn` high clears each defined bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R3: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: Bit 0 sets when the selected timer MSB changes in either direction. `msbSel`=0 selects `tmrTaps[0]` (timer bit 23) and `msbSel`=1 selects `tmrTaps[1]` (timer bit 31). A change on the tap that is not selected has no effect.
- R5: Bit 4 sets when any `busReq` line is high. Bit 5 sets on `biosRlsPulse`. Bit 10 sets on `rtcIrqPulse`.
- R6: Bit 15 sets on `resumeEvt` only while `sleepActive` is high.
- R7: A power button level that is low and stable for DEB_TICKS ticks sets bit 8. With one tick per cycle, the bit is first visible DEB_TICKS+4 clock edges after the pin changes. A low pulse shorter than the window sets nothing.
- R8: Debounce also applies to release. A high glitch shorter than the window during a held press does not end the press, so no second press is reported.
- R9: Bit 9 can set only while `slpFuncSel` is high. When `gpioDebEn` is high, the sleep button window is 2*DEB_TICKS ticks, so the bit first shows 2*DEB_TICKS+4 edges after the pin changes.
- R10: With `pwrOvrDis` low, a debounced power press held for more than HOLD_TICKS ticks clears bit 8 and sets bit 11. This happens HOLD_TICKS+1 edges after bit 8 appeared. With `pwrOvrDis` high, the hold has no effect.
- R11: With `slpOvrDis` low and `slpFuncSel` high, a sleep press held for more than HOLD_TICKS ticks clears bit 9 and sets bit 11. With `slpOvrDis` high, the hold has no effect.
- R12: A continuing hold yields a single override event. A new one needs a debounced release and a fresh hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per slow tick |
| pwrBtnN | input | 1 | Raw power button, active low |
| slpBtnN | input | 1 | Raw sleep button, active low |
| pwrOvrDis | input | 1 | Disables power button hold override |
| slpOvrDis | input | 1 | Disables sleep button hold override |
| slpFuncSel | input | 1 | Sleep button function selected |
| gpioDebEn | input | 1 | Doubles the sleep button debounce window |
| tmrTaps | input | 2 | Timer bit 23 in [0], timer bit 31 in [1] |
| msbSel | input | 1 | 0 watches tap 0, 1 watches tap 1 |
| busReq | input | NREQ | Bus-master request lines |
| biosRlsPulse | input | 1 | Firmware release event |
| rtcIrqPulse | input | 1 | Real-time clock interrupt event |
| resumeEvt | input | 1 | Resume event |
| sleepActive | input | 1 | System is in a sleep state |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 16 | Write-one-to-clear mask |
| status | output | 16 | Status word |

## Verification
The main collision is a hardware event and a software clear landing on the same status bit in the same clock. The bench provokes it by raising the RTC pulse and a write of bit 10 on the same negative edge. It expects bit 10 to read 1 afterwards. A second overlap occurs when an override clears a button bit while the shared override bit sets in that same cycle. The bench checks that both changes appear together, at the exact edge computed from the debounce and hold counts.

// File: rtl/pmStatusPkg.sv
package pmStatusPkg;
  localparam int STAT_W  = 16;
  localparam int BIT_TMR = 0;
  localparam int BIT_BM  = 4;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_SLP = 9;
  localparam int BIT_RTC = 10;
  localparam int BIT_OVR = 11;
  localparam int BIT_WAK = 15;
  localparam logic [STAT_W-1:0] STAT_MASK = 16'h8F31;

  typedef struct packed {
    logic setTmr;
    logic setBm;
    logic setGbl;
    logic setPwr;
    logic setSlp;
    logic setRtc;
    logic setOvr;
    logic setWak;
    logic clrPwr;
    logic clrSlp;
  } statStrobe_t;
endpackage

// File: rtl/pmBtnConditioner.sv
module pmBtnConditioner #(
  parameter int DEB_TICKS  = 459,
  parameter int HOLD_TICKS = 131072
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawN,
  input  logic dblWin,
  output logic pressEvt,
  output logic holdEvt
);
  localparam int DEB_MAX = 2 * DEB_TICKS;
  localparam int CNT_W   = $clog2(DEB_MAX + 1);
  localparam int HOLD_W  = $clog2(HOLD_TICKS + 1);

  logic syncA, syncB, rawPrev;
  logic stableN;
  logic [CNT_W-1:0]  debCnt;
  logic [CNT_W-1:0]  debLast;
  logic [HOLD_W-1:0] holdCnt;
  logic fired;

  // last count value of the active window
  always_comb begin
    debLast = dblWin ? CNT_W'(DEB_MAX - 1) : CNT_W'(DEB_TICKS - 1);
  end

  // synchronizer and debounce: counter restarts whenever the level moves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      rawPrev  <= 1'b1;
      stableN  <= 1'b1;
      debCnt   <= '0;
      pressEvt <= 1'b0;
    end else begin
      syncA    <= rawN;
      syncB    <= syncA;
      rawPrev  <= syncB;
      pressEvt <= 1'b0;
      if ((syncB != rawPrev) || (syncB == stableN)) begin
        debCnt <= '0;
      end else if (tick) begin
        if (debCnt >= debLast) begin
          stableN  <= syncB;
          debCnt   <= '0;
          pressEvt <= ~syncB;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end
    end
  end

  // long-hold detector, one event per debounced press
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      fired   <= 1'b0;
      holdEvt <= 1'b0;
    end else begin
      holdEvt <= 1'b0;
      if (stableN) begin
        holdCnt <= '0;
        fired   <= 1'b0;
      end else if (tick && !fired) begin
        if (holdCnt == HOLD_W'(HOLD_TICKS)) begin
          fired   <= 1'b1;
          holdEvt <= 1'b1;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  end

  a_r12_single_hold: assert property (@(posedge clk) disable iff (!rstN)
    holdEvt |=> !holdEvt);
  a_r12_hold_needs_press: assert property (@(posedge clk) disable iff (!rstN)
    holdEvt |-> !stableN);
  a_r8_accept_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stableN) |-> ($past(syncB) == stableN));
  a_r7_press_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    pressEvt |-> (!stableN && $past(stableN)));
endmodule

// File: rtl/pmStatusCtrl.sv
module pmStatusCtrl
  import pmStatusPkg::*;
#(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwrPress,
  input  logic            pwrHold,
  input  logic            slpPress,
  input  logic            slpHold,
  input  logic            pwrOvrDis,
  input  logic            slpOvrDis,
  input  logic            slpFuncSel,
  input  logic [1:0]      tmrTaps,
  input  logic            msbSel,
  input  logic [NREQ-1:0] busReq,
  input  logic            biosRlsPulse,
  input  logic            rtcIrqPulse,
  input  logic            resumeEvt,
  input  logic            sleepActive,
  output statStrobe_t     strobe
);
  logic msbNow, prevMsb, prevSel, primed;
  logic pwrOvr, slpOvr;

  assign msbNow = msbSel ? tmrTaps[1] : tmrTaps[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMsb <= 1'b0;
      prevSel <= 1'b0;
      primed  <= 1'b0;
    end else begin
      prevMsb <= msbNow;
      prevSel <= msbSel;
      primed  <= 1'b1;
    end
  end

  always_comb begin
    pwrOvr = pwrHold && !pwrOvrDis;
    slpOvr = slpHold && !slpOvrDis && slpFuncSel;
    strobe.setTmr = primed && (prevSel == msbSel) && (msbNow != prevMsb);
    strobe.setBm  = |busReq;
    strobe.setGbl = biosRlsPulse;
    strobe.setRtc = rtcIrqPulse;
    strobe.setWak = resumeEvt && sleepActive;
    strobe.setPwr = pwrPress;
    strobe.setSlp = slpPress && slpFuncSel;
    strobe.setOvr = pwrOvr || slpOvr;
    strobe.clrPwr = pwrOvr;
    strobe.clrSlp = slpOvr;
  end

  a_r4_tap0_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !msbSel && !$past(msbSel) && (tmrTaps[0] != $past(tmrTaps[0])))
    |-> strobe.setTmr);
  a_r4_tap1_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (primed && msbSel && $past(msbSel) && (tmrTaps[1] != $past(tmrTaps[1])))
    |-> strobe.setTmr);
  a_r4_quiet_timer: assert property (@(posedge clk) disable iff (!rstN)
    $stable(tmrTaps) |-> !strobe.setTmr);
endmodule

// File: rtl/pmStatusRegs.sv
module pmStatusRegs
  import pmStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statQ
);
  logic [STAT_W-1:0] setVec, clrVec, swClr;

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[BIT_TMR] = strobe.setTmr;
    setVec[BIT_BM]  = strobe.setBm;
    setVec[BIT_GBL] = strobe.setGbl;
    setVec[BIT_PWR] = strobe.setPwr;
    setVec[BIT_SLP] = strobe.setSlp;
    setVec[BIT_RTC] = strobe.setRtc;
    setVec[BIT_OVR] = strobe.setOvr;
    setVec[BIT_WAK] = strobe.setWak;
    clrVec[BIT_PWR] = strobe.clrPwr;
    clrVec[BIT_SLP] = strobe.clrSlp;
    swClr = wrEn ? wrData : '0;
  end

  // priority: override clear, then hardware set, then software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (((statQ & ~swClr) | setVec) & ~clrVec) & STAT_MASK;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bitChk
    if (STAT_MASK[i]) begin : g_live
      a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
        (setVec[i] && !clrVec[i]) |=> statQ[i]);
      a_r10_hw_clear: assert property (@(posedge clk) disable iff (!rstN)
        clrVec[i] |=> !statQ[i]);
      a_r2_w1c: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && wrData[i] && !setVec[i]) |=> !statQ[i]);
      a_r2_keep: assert property (@(posedge clk) disable iff (!rstN)
        (!setVec[i] && !clrVec[i] && !(wrEn && wrData[i])) |=> $stable(statQ[i]));
    end else begin : g_rsvd
      a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && wrData[i]) |=> !statQ[i]);
    end
  end
endmodule

// File: rtl/pmEventStatus.sv
module pmEventStatus
  import pmStatusPkg::*;
#(
  parameter int DEB_TICKS  = 459,
  parameter int HOLD_TICKS = 131072,
  parameter int NREQ       = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            pwrBtnN,
  input  logic            slpBtnN,
  input  logic            pwrOvrDis,
  input  logic            slpOvrDis,
  input  logic            slpFuncSel,
  input  logic            gpioDebEn,
  input  logic [1:0]      tmrTaps,
  input  logic            msbSel,
  input  logic [NREQ-1:0] busReq,
  input  logic            biosRlsPulse,
  input  logic            rtcIrqPulse,
  input  logic            resumeEvt,
  input  logic            sleepActive,
  input  logic            wrEn,
  input  logic [15:0]     wrData,
  output logic [15:0]     status
);
  logic pwrPress, pwrHold, slpPress, slpHold;
  statStrobe_t strobe;

  pmBtnConditioner #(.DEB_TICKS(DEB_TICKS), .HOLD_TICKS(HOLD_TICKS)) pwrCond_i (
    .clk(clk), .rstN(rstN), .tick(tick), .rawN(pwrBtnN), .dblWin(1'b0),
    .pressEvt(pwrPress), .holdEvt(pwrHold));

  pmBtnConditioner #(.DEB_TICKS(DEB_TICKS), .HOLD_TICKS(HOLD_TICKS)) slpCond_i (
    .clk(clk), .rstN(rstN), .tick(tick), .rawN(slpBtnN), .dblWin(gpioDebEn),
    .pressEvt(slpPress), .holdEvt(slpHold));

  pmStatusCtrl #(.NREQ(NREQ)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .pwrPress(pwrPress), .pwrHold(pwrHold), .slpPress(slpPress), .slpHold(slpHold),
    .pwrOvrDis(pwrOvrDis), .slpOvrDis(slpOvrDis), .slpFuncSel(slpFuncSel),
    .tmrTaps(tmrTaps), .msbSel(msbSel), .busReq(busReq),
    .biosRlsPulse(biosRlsPulse), .rtcIrqPulse(rtcIrqPulse),
    .resumeEvt(resumeEvt), .sleepActive(sleepActive), .strobe(strobe));

  pmStatusRegs regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrData(wrData),
    .statQ(status));

  a_r6_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_WAK]) |-> $past(sleepActive));
  a_r9_slp_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_SLP]) |-> $past(slpFuncSel));
  a_r11_ovr_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_OVR]) |-> ($past(!pwrOvrDis) || $past(!slpOvrDis)));
endmodule

// File: tb/pmEventStatus_tb_top.sv
module pmEventStatus_tb_top;
  localparam int DEB  = 6;
  localparam int HOLD = 40;
  localparam int NREQ = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic pwrBtnN = 1'b1, slpBtnN = 1'b1;
  logic pwrOvrDis = 1'b0, slpOvrDis = 1'b0, slpFuncSel = 1'b0, gpioDebEn = 1'b0;
  logic [1:0] tmrTaps = 2'b00;
  logic msbSel = 1'b0;
  logic [NREQ-1:0] busReq = '0;
  logic biosRlsPulse = 1'b0, rtcIrqPulse = 1'b0, resumeEvt = 1'b0, sleepActive = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] status;

  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pmEventStatus #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .NREQ(NREQ)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .pwrBtnN(pwrBtnN), .slpBtnN(slpBtnN),
    .pwrOvrDis(pwrOvrDis), .slpOvrDis(slpOvrDis), .slpFuncSel(slpFuncSel),
    .gpioDebEn(gpioDebEn), .tmrTaps(tmrTaps), .msbSel(msbSel), .busReq(busReq),
    .biosRlsPulse(biosRlsPulse), .rtcIrqPulse(rtcIrqPulse), .resumeEvt(resumeEvt),
    .sleepActive(sleepActive), .wrEn(wrEn), .wrData(wrData), .status(status));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: status=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic swClear(input logic [15:0] m);
    @(negedge clk); wrEn = 1'b1; wrData = m;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: status=%h expected=done", status);
      report();
    end
  end

  initial begin
    logic [15:0] exp;
    waitCyc(3);
    check("R1 reset", status, 16'h0000);
    rstN = 1'b1;
    waitCyc(3);
    check("R1 after release", status, 16'h0000);

    // R5 bus request sweep over every line
    for (int i = 0; i < NREQ; i++) begin
      @(negedge clk); busReq = NREQ'(1) << i;
      @(negedge clk); busReq = '0;
      check("R5 busReq line", status, 16'h0010);
      swClear(16'h0010);
      check("R2 clear bus bit", status, 16'h0000);
    end
    @(negedge clk); biosRlsPulse = 1'b1;
    @(negedge clk); biosRlsPulse = 1'b0;
    check("R5 global", status, 16'h0020);
    @(negedge clk); rtcIrqPulse = 1'b1;
    @(negedge clk); rtcIrqPulse = 1'b0;
    check("R5 rtc", status, 16'h0420);

    // R6 wake gating
    @(negedge clk); resumeEvt = 1'b1;
    @(negedge clk); resumeEvt = 1'b0;
    check("R6 resume while awake", status, 16'h0420);
    sleepActive = 1'b1;
    @(negedge clk); resumeEvt = 1'b1;
    @(negedge clk); resumeEvt = 1'b0; sleepActive = 1'b0;
    check("R6 resume while asleep", status, 16'h8420);

    // R4 timer taps
    @(negedge clk); tmrTaps[0] = 1'b1;
    @(negedge clk);
    check("R4 tap0 rise", status, 16'h8421);
    swClear(16'h0001);
    @(negedge clk); tmrTaps[0] = 1'b0;
    @(negedge clk);
    check("R4 tap0 fall", status, 16'h8421);
    swClear(16'h0001);
    @(negedge clk); tmrTaps[1] = 1'b1;
    waitCyc(2);
    check("R4 unselected tap ignored", status, 16'h8420);
    @(negedge clk); msbSel = 1'b1;
    waitCyc(2);
    check("R4 select change no event", status, 16'h8420);
    @(negedge clk); tmrTaps[1] = 1'b0;
    @(negedge clk);
    check("R4 tap1 fall", status, 16'h8421);

    // R2 write zero keeps, then per-bit clear sweep
    swClear(16'h0000);
    check("R2 write zero", status, 16'h8421);
    exp = 16'h8421;
    for (int b = 0; b < 16; b++) begin
      swClear(16'(1) << b);
      exp = exp & ~(16'(1) << b);
      check("R2 single-bit clear", status, exp);
    end

    // R3 collision of set and clear
    @(negedge clk); rtcIrqPulse = 1'b1;
    @(negedge clk); rtcIrqPulse = 1'b0;
    @(negedge clk); rtcIrqPulse = 1'b1; wrEn = 1'b1; wrData = 16'h0400;
    @(negedge clk); rtcIrqPulse = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R3 set beats clear", status, 16'h0400);
    swClear(16'hFFFF);
    check("R1 reserved after FFFF", status, 16'h0000);

    // R7 short bounce ignored, then exact debounce timing
    @(negedge clk); pwrBtnN = 1'b0;
    waitCyc(3); pwrBtnN = 1'b1;
    waitCyc(30);
    check("R7 short low pulse", status, 16'h0000);
    pwrOvrDis = 1'b1;
    pwrBtnN = 1'b0;
    waitCyc(DEB + 3);
    check("R7 before window", status, 16'h0000);
    waitCyc(1);
    check("R7 press visible", status, 16'h0100);
    swClear(16'h0100);
    // R8 release glitch during held press
    pwrBtnN = 1'b1;
    waitCyc(3); pwrBtnN = 1'b0;
    waitCyc(HOLD + 30);
    check("R8 release glitch / R10 override disabled", status, 16'h0000);
    pwrBtnN = 1'b1;
    waitCyc(DEB + 10);
    pwrOvrDis = 1'b0;

    // R10 power override at exact edge
    pwrBtnN = 1'b0;
    waitCyc(DEB + 4);
    check("R10 press first", status, 16'h0100);
    waitCyc(HOLD);
    check("R10 before threshold", status, 16'h0100);
    waitCyc(1);
    check("R10 override", status, 16'h0800);
    swClear(16'h0800);
    waitCyc(HOLD + 20);
    check("R12 one event per hold", status, 16'h0000);
    pwrBtnN = 1'b1;
    waitCyc(DEB + 10);

    // R9 sleep gating and window lengths
    slpBtnN = 1'b0;
    waitCyc(DEB + 10);
    check("R9 sleep without function", status, 16'h0000);
    slpBtnN = 1'b1;
    waitCyc(DEB + 10);
    slpFuncSel = 1'b1;
    slpOvrDis = 1'b1;
    slpBtnN = 1'b0;
    waitCyc(DEB + 3);
    check("R9 sleep before window", status, 16'h0000);
    waitCyc(1);
    check("R9 sleep press", status, 16'h0200);
    waitCyc(HOLD + 10);
    check("R11 override disabled", status, 16'h0200);
    swClear(16'h0200);
    slpBtnN = 1'b1;
    waitCyc(DEB + 10);
    slpOvrDis = 1'b0;
    gpioDebEn = 1'b1;
    slpBtnN = 1'b0;
    waitCyc(2 * DEB + 3);
    check("R9 doubled window pending", status, 16'h0000);
    waitCyc(1);
    check("R9 doubled window press", status, 16'h0200);
    waitCyc(HOLD);
    check("R11 before threshold", status, 16'h0200);
    waitCyc(1);
    check("R11 sleep override", status, 16'h0800);
    swClear(16'h0800);
    waitCyc(HOLD + 20);
    check("R12 sleep hold once", status, 16'h0000);
    slpBtnN = 1'b1;
    waitCyc(2 * DEB + 10);
    slpBtnN = 1'b0;
    waitCyc(2 * DEB + 4 + HOLD + 1);
    check("R12 re-armed after release", status, 16'h0800);
    slpBtnN = 1'b1;

    done = 1'b1;
    report();
  end
endmodule